// File: doc/BRIEF.md
# Compression Metadata Table Walker

This block turns a 48-bit main-surface graphics address into the address of the compression metadata that describes it. It does this by walking a three-level translation table in memory. Software first loads a 64-bit table base register as two 32-bit words. A lookup request then carries the main-surface address in. The walker issues one 64-bit read per level through a request/response memory port and checks the valid bit of each entry it fetches. When all three levels are valid, it returns the metadata address together with the surface attribute fields held in the leaf entry. Otherwise it reports a fault and names the level at which the walk stopped.

The three levels differ. The top level and the middle level are each indexed by 12 address bits, and the leaf level is indexed by 8. The alignment of the next-table pointer also changes at each step. A leaf entry covers one 64 KiB block of the main surface and points to a 256-byte metadata block. That works out to two metadata bits for every 64-byte main-surface line.

Back-pressure rules:
- Lookup port: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only one lookup is in flight at a time.
- Memory request port: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen high at a clock edge.
- Memory response port: it has no ready signal. The walker always accepts exactly one response for each read it issued.
- Results: they appear with a single-cycle `done` pulse and have no ready signal.

Top module: `ccs_meta_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `mem_req_valid` and `seq_err` are 0.
- R2: Writing with `base_hi`=1 loads base bits [63:32], and writing with `base_hi`=0 loads base bits [31:0]. The top-level table starts at base bits [47:3], with bits [2:0] taken as zero.
- R3: The walker reads the top entry at base + addr[47:36]*8, then the middle entry at middle_table + addr[35:24]*8, then the leaf entry at leaf_table + addr[23:16]*8. A complete walk makes exactly 3 reads.
- R4: The middle table address is top-entry bits [47:15] with bits [14:0] zero. The leaf table address is middle-entry bits [47:13] with bits [12:0] zero. Entry bits [63:48] never take part in an address.
- R5: On success, `meta_addr` = {leaf bits [47:8], 8'b0} + addr[15:8].
- R6: On success, the walker outputs these leaf fields: `comp_mode`=bits [2:1], `lossy`=bit 3, `tile_mode`=bits [53:52], `depth_code`=bits [56:54], `ycr`=bit 57, `fmt_code`=bits [63:58].
- R7: An entry whose bit 0 is 0 ends the walk with `fault`=1. `fault_level` is 2 for the top level, 1 for the middle level and 0 for the leaf level. No further read follows, and `meta_addr` and all attribute fields are 0.
- R8: A lookup accepted while the whole 64-bit base is zero faults with `fault_level`=3 and makes no memory read. `done` rises in the cycle right after acceptance.
- R9: `req_ready` is 0 while a walk is in progress. `done` lasts exactly one cycle.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged in the next cycle.
- R11: A memory response that arrives while no read is outstanding raises `seq_err` for one cycle, in the next cycle. It is otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_we | input | 1 | Base register word write strobe |
| base_hi | input | 1 | 1: upper word (offset +4), 0: lower word |
| base_wdata | input | 32 | Base register write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle, able to take a lookup |
| req_addr | input | 48 | Main-surface address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (one table entry) |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk failed |
| fault_level | output | 2 | Level of failure (3 = no base) |
| meta_addr | output | 48 | Translated metadata address |
| comp_mode | output | 2 | Compression mode field |
| lossy | output | 1 | Lossy compression flag |
| tile_mode | output | 2 | Tiling field |
| depth_code | output | 3 | Pixel depth code |
| ycr | output | 1 | YCr flag |
| fmt_code | output | 6 | Surface format code |
| seq_err | output | 1 | Unexpected read response seen |

## Verification
The lookup addresses come from a vector table, and each one is chosen to separate a different part of the walk. One address is fully mapped through entries that carry junk in their low and high bits, which separates correct pointer masking from plain copying. A second address shares that path but uses another leaf and the top byte offset, which separates the leaf index from the metadata offset. A third uses the maximum top index and a zero offset, which exposes index truncation. Three further addresses each stop at a different level, which separates the fault levels and the read counts. Directed runs add a zero base, a base held only in the upper word, a stalled memory request port and a stray response; between them they tell apart the two base halves, the handling of held requests and the detection of out-of-order responses.

// File: rtl/ccsw_pkg.sv
package ccsw_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ISSUE = 2'd1,
    WS_WAIT  = 2'd2
  } walk_state_e;

  // Level codes reported on fault_level
  localparam logic [1:0] LVL_LEAF   = 2'd0;
  localparam logic [1:0] LVL_MID    = 2'd1;
  localparam logic [1:0] LVL_TOP    = 2'd2;
  localparam logic [1:0] LVL_NOBASE = 2'd3;

  localparam int ENTRY_W   = 64;
  localparam int ENT_SHIFT = 3;   // 8 bytes per entry

  // Leaf entry field positions
  localparam int VALID_BIT = 0;
  localparam int COMP_LSB  = 1;
  localparam int LOSSY_BIT = 3;
  localparam int TILE_LSB  = 52;
  localparam int DEPTH_LSB = 54;
  localparam int YCR_BIT   = 57;
  localparam int FMT_LSB   = 58;

  typedef struct packed {
    logic [1:0] comp;
    logic       lossy;
    logic [1:0] tile;
    logic [2:0] depth;
    logic       ycr;
    logic [5:0] fmt;
  } leaf_attr_t;

endpackage

// File: rtl/ccsw_base_reg.sv
module ccsw_base_reg #(
  parameter int ADDR_W = 48,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              base_hi,
  input  logic [REG_W-1:0]  base_wdata,
  output logic              base_zero,
  output logic [ADDR_W-1:0] base_ptr
);
  import ccsw_pkg::*;

  localparam int WORDS = ENTRY_W / REG_W;

  logic [REG_W-1:0] word_q [WORDS];
  logic [ENTRY_W-1:0] base_full;

  for (genvar h = 0; h < WORDS; h++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[h] <= '0;
      end else if (base_we && (base_hi == 1'(h))) begin
        word_q[h] <= base_wdata;
      end
    end
    assign base_full[h*REG_W +: REG_W] = word_q[h];
  end

  assign base_zero = (base_full == '0);
  assign base_ptr  = {base_full[ADDR_W-1:ENT_SHIFT], {ENT_SHIFT{1'b0}}};

endmodule

// File: rtl/ccsw_entry_addr.sv
module ccsw_entry_addr #(
  parameter int ADDR_W       = 48,
  parameter int LEAF_IDX_LSB = 16,
  parameter int MID_IDX_LSB  = 24,
  parameter int TOP_IDX_LSB  = 36
) (
  input  logic [1:0]        lvl,
  input  logic [ADDR_W-1:0] tbl,
  input  logic [ADDR_W-1:0] va,
  output logic [ADDR_W-1:0] entry_addr
);
  import ccsw_pkg::*;

  logic [ADDR_W-1:0] cand [3];

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    localparam int LO = (g == 0) ? LEAF_IDX_LSB : (g == 1) ? MID_IDX_LSB : TOP_IDX_LSB;
    localparam int HI = (g == 0) ? MID_IDX_LSB  : (g == 1) ? TOP_IDX_LSB : ADDR_W;
    logic [HI-LO-1:0] idx;
    assign idx     = va[HI-1:LO];
    assign cand[g] = tbl + ADDR_W'({idx, {ENT_SHIFT{1'b0}}});
  end

  always_comb begin
    case (lvl)
      LVL_LEAF: entry_addr = cand[0];
      LVL_MID:  entry_addr = cand[1];
      default:  entry_addr = cand[2];
    endcase
  end

  logic unused_va_lo;
  assign unused_va_lo = ^va[LEAF_IDX_LSB-1:0];

endmodule

// File: rtl/ccsw_entry_decode.sv
module ccsw_entry_decode #(
  parameter int ADDR_W       = 48,
  parameter int TOP_PTR_LSB  = 15,
  parameter int MID_PTR_LSB  = 13,
  parameter int LEAF_PTR_LSB = 8
) (
  input  logic [63:0]            entry,
  output logic                   ent_valid,
  output logic [ADDR_W-1:0]      mid_tbl,
  output logic [ADDR_W-1:0]      leaf_tbl,
  output logic [ADDR_W-1:0]      meta_base,
  output ccsw_pkg::leaf_attr_t   attr
);
  import ccsw_pkg::*;

  assign ent_valid = entry[VALID_BIT];
  assign mid_tbl   = {entry[ADDR_W-1:TOP_PTR_LSB],  {TOP_PTR_LSB{1'b0}}};
  assign leaf_tbl  = {entry[ADDR_W-1:MID_PTR_LSB],  {MID_PTR_LSB{1'b0}}};
  assign meta_base = {entry[ADDR_W-1:LEAF_PTR_LSB], {LEAF_PTR_LSB{1'b0}}};

  always_comb begin
    attr.comp  = entry[COMP_LSB +: 2];
    attr.lossy = entry[LOSSY_BIT];
    attr.tile  = entry[TILE_LSB +: 2];
    attr.depth = entry[DEPTH_LSB +: 3];
    attr.ycr   = entry[YCR_BIT];
    attr.fmt   = entry[FMT_LSB +: 6];
  end

  logic unused_pad;
  assign unused_pad = ^{entry[LEAF_PTR_LSB-1:LOSSY_BIT+1], entry[TILE_LSB-1:ADDR_W]};

endmodule

// File: rtl/ccsw_walk_fsm.sv
module ccsw_walk_fsm #(
  parameter int ADDR_W       = 48,
  parameter int LEAF_IDX_LSB = 16,
  parameter int LEAF_PTR_LSB = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_ready,
  input  logic                 base_zero,
  input  logic [ADDR_W-1:0]    base_ptr,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  input  logic                 mem_rsp_valid,
  input  logic                 ent_valid,
  input  logic [ADDR_W-1:0]    mid_tbl,
  input  logic [ADDR_W-1:0]    leaf_tbl,
  input  logic [ADDR_W-1:0]    meta_base,
  input  ccsw_pkg::leaf_attr_t attr,
  output logic [1:0]           lvl,
  output logic [ADDR_W-1:0]    tbl,
  output logic [ADDR_W-1:0]    va,
  output logic                 done,
  output logic                 fault,
  output logic [1:0]           fault_level,
  output logic [ADDR_W-1:0]    meta_addr,
  output ccsw_pkg::leaf_attr_t attr_q,
  output logic                 seq_err
);
  import ccsw_pkg::*;

  localparam int OFF_W = LEAF_IDX_LSB - LEAF_PTR_LSB;

  walk_state_e st;

  assign req_ready     = (st == WS_IDLE);
  assign mem_req_valid = (st == WS_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= WS_IDLE;
      lvl         <= LVL_TOP;
      tbl         <= '0;
      va          <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= LVL_LEAF;
      meta_addr   <= '0;
      attr_q      <= '0;
      seq_err     <= 1'b0;
    end else begin
      done    <= 1'b0;
      seq_err <= mem_rsp_valid && (st != WS_WAIT);
      case (st)
        WS_IDLE: begin
          if (req_valid) begin
            va <= req_addr;
            if (base_zero) begin
              done        <= 1'b1;
              fault       <= 1'b1;
              fault_level <= LVL_NOBASE;
              meta_addr   <= '0;
              attr_q      <= '0;
            end else begin
              tbl <= base_ptr;
              lvl <= LVL_TOP;
              st  <= WS_ISSUE;
            end
          end
        end
        WS_ISSUE: begin
          if (mem_req_ready) st <= WS_WAIT;
        end
        WS_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              done        <= 1'b1;
              fault       <= 1'b1;
              fault_level <= lvl;
              meta_addr   <= '0;
              attr_q      <= '0;
              st          <= WS_IDLE;
            end else if (lvl == LVL_LEAF) begin
              done        <= 1'b1;
              fault       <= 1'b0;
              fault_level <= LVL_LEAF;
              meta_addr   <= meta_base + ADDR_W'(va[LEAF_IDX_LSB-1 -: OFF_W]);
              attr_q      <= attr;
              st          <= WS_IDLE;
            end else begin
              tbl <= (lvl == LVL_TOP) ? mid_tbl : leaf_tbl;
              lvl <= lvl - 2'd1;
              st  <= WS_ISSUE;
            end
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccs_meta_walker.sv
module ccs_meta_walker #(
  parameter int ADDR_W       = 48,
  parameter int REG_W        = 32,
  parameter int LEAF_IDX_LSB = 16,
  parameter int MID_IDX_LSB  = 24,
  parameter int TOP_IDX_LSB  = 36,
  parameter int TOP_PTR_LSB  = 15,
  parameter int MID_PTR_LSB  = 13,
  parameter int LEAF_PTR_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              base_hi,
  input  logic [REG_W-1:0]  base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_level,
  output logic [ADDR_W-1:0] meta_addr,
  output logic [1:0]        comp_mode,
  output logic              lossy,
  output logic [1:0]        tile_mode,
  output logic [2:0]        depth_code,
  output logic              ycr,
  output logic [5:0]        fmt_code,
  output logic              seq_err
);
  import ccsw_pkg::*;

  logic              base_zero;
  logic [ADDR_W-1:0] base_ptr;
  logic [1:0]        lvl;
  logic [ADDR_W-1:0] tbl;
  logic [ADDR_W-1:0] va;
  logic              ent_valid;
  logic [ADDR_W-1:0] mid_tbl;
  logic [ADDR_W-1:0] leaf_tbl;
  logic [ADDR_W-1:0] meta_base;
  leaf_attr_t        attr;
  leaf_attr_t        attr_q;

  ccsw_base_reg #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_hi    (base_hi),
    .base_wdata (base_wdata),
    .base_zero  (base_zero),
    .base_ptr   (base_ptr)
  );

  ccsw_entry_addr #(
    .ADDR_W(ADDR_W), .LEAF_IDX_LSB(LEAF_IDX_LSB),
    .MID_IDX_LSB(MID_IDX_LSB), .TOP_IDX_LSB(TOP_IDX_LSB)
  ) u_addr (
    .lvl        (lvl),
    .tbl        (tbl),
    .va         (va),
    .entry_addr (mem_req_addr)
  );

  ccsw_entry_decode #(
    .ADDR_W(ADDR_W), .TOP_PTR_LSB(TOP_PTR_LSB),
    .MID_PTR_LSB(MID_PTR_LSB), .LEAF_PTR_LSB(LEAF_PTR_LSB)
  ) u_dec (
    .entry     (mem_rsp_data),
    .ent_valid (ent_valid),
    .mid_tbl   (mid_tbl),
    .leaf_tbl  (leaf_tbl),
    .meta_base (meta_base),
    .attr      (attr)
  );

  ccsw_walk_fsm #(
    .ADDR_W(ADDR_W), .LEAF_IDX_LSB(LEAF_IDX_LSB), .LEAF_PTR_LSB(LEAF_PTR_LSB)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_ready     (req_ready),
    .base_zero     (base_zero),
    .base_ptr      (base_ptr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .ent_valid     (ent_valid),
    .mid_tbl       (mid_tbl),
    .leaf_tbl      (leaf_tbl),
    .meta_base     (meta_base),
    .attr          (attr),
    .lvl           (lvl),
    .tbl           (tbl),
    .va            (va),
    .done          (done),
    .fault         (fault),
    .fault_level   (fault_level),
    .meta_addr     (meta_addr),
    .attr_q        (attr_q),
    .seq_err       (seq_err)
  );

  assign comp_mode  = attr_q.comp;
  assign lossy      = attr_q.lossy;
  assign tile_mode  = attr_q.tile;
  assign depth_code = attr_q.depth;
  assign ycr        = attr_q.ycr;
  assign fmt_code   = attr_q.fmt;

endmodule

// File: rtl/ccsw_walker_chk.sv
module ccsw_walker_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] meta_addr,
  input logic              seq_err
);

  // R10: a stalled read request holds and keeps its address
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9: no memory read while the lookup port is open
  p_idle_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  // R7: a fault result carries no address and no read is pending
  p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> !mem_req_valid && (meta_addr == '0));

  // R11: a response while idle is flagged next cycle
  p_stray_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && req_ready |=> seq_err);

  // R11: no flag without a response
  p_no_false_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |=> !seq_err);

endmodule

bind ccs_meta_walker ccsw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .meta_addr     (meta_addr),
  .seq_err       (seq_err)
);

// File: tb/ccs_meta_walker_test.sv
`timescale 1ns/1ps
module ccs_meta_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic        base_hi = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_addr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, fault, lossy, ycr, seq_err;
  logic [1:0]  fault_level, comp_mode, tile_mode;
  logic [2:0]  depth_code;
  logic [5:0]  fmt_code;
  logic [47:0] meta_addr;

  always #2.5 clk = ~clk;

  ccs_meta_walker uut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_hi(base_hi),
    .base_wdata(base_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level),
    .meta_addr(meta_addr), .comp_mode(comp_mode), .lossy(lossy),
    .tile_mode(tile_mode), .depth_code(depth_code), .ycr(ycr),
    .fmt_code(fmt_code), .seq_err(seq_err)
  );

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [47:0]];
  logic        mdl_valid = 1'b0;
  logic [63:0] mdl_data = '0;
  logic        stray = 1'b0;
  logic        stall_on = 1'b0;
  logic [1:0]  cyc = '0;
  int          rd_cnt = 0;
  logic [47:0] last_addr = '0;

  assign mem_req_ready = !stall_on || (cyc == 2'b11);
  assign mem_rsp_valid = mdl_valid | stray;
  assign mem_rsp_data  = mdl_data;

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (mem_req_valid && mem_req_ready) begin
      mdl_valid <= 1'b1;
      mdl_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
      rd_cnt    <= rd_cnt + 1;
      last_addr <= mem_req_addr;
    end else begin
      mdl_valid <= 1'b0;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // attr packing {comp[1:0], lossy, tile[1:0], depth[2:0], ycr, fmt[5:0]}
  function automatic logic [63:0] mk_leaf(input logic [47:0] ptr, input logic [14:0] a);
    logic [63:0] e;
    e = '0;
    e[47:8]  = ptr[47:8];
    e[0]     = 1'b1;
    e[2:1]   = a[14:13];
    e[3]     = a[12];
    e[7:4]   = 4'hA;          // ignored pad
    e[51:48] = 4'h5;          // ignored pad
    e[53:52] = a[11:10];
    e[56:54] = a[9:7];
    e[57]    = a[6];
    e[63:58] = a[5:0];
    return e;
  endfunction

  function automatic logic [47:0] ea(input logic [47:0] t, input int idx);
    return t + 48'(idx * 8);
  endfunction

  typedef struct packed {
    logic [47:0] va;
    logic        flt;
    logic [1:0]  lvl;
    logic [47:0] meta;
    logic [14:0] attr;
    logic [2:0]  reads;
  } vec_t;

  localparam logic [14:0] AT_A = {2'd2, 1'b1, 2'd1, 3'd5, 1'b0, 6'h0A};
  localparam logic [14:0] AT_B = {2'd1, 1'b0, 2'd2, 3'd3, 1'b1, 6'h3F};
  localparam logic [14:0] AT_C = {2'd3, 1'b0, 2'd0, 3'd0, 1'b0, 6'h01};

  localparam vec_t VECS [6] = '{
    '{48'h0012_3456_7890, 1'b0, 2'd0, 48'h0000_1234_5678, AT_A,  3'd3},
    '{48'h0012_34A0_FF00, 1'b0, 2'd0, 48'hFFFF_FFFF_FFFF, AT_B,  3'd3},
    '{48'hFFF0_0000_0012, 1'b0, 2'd0, 48'h0000_0000_0100, AT_C,  3'd3},
    '{48'h0020_0000_0000, 1'b1, 2'd2, 48'h0,              15'd0, 3'd1},
    '{48'h0012_3500_0000, 1'b1, 2'd1, 48'h0,              15'd0, 3'd2},
    '{48'h0012_3457_0000, 1'b1, 2'd0, 48'h0,              15'd0, 3'd3}
  };

  // lookup results
  logic        r_done, r_fault, r_after, r_busy;
  logic [1:0]  r_lvl;
  logic [47:0] r_meta;
  logic [14:0] r_attr;
  int          r_reads, r_wait;

  task automatic do_lookup(input logic [47:0] va);
    int start;
    @(negedge clk);
    start = rd_cnt;
    req_valid = 1'b1;
    req_addr  = va;
    @(negedge clk);
    req_valid = 1'b0;
    r_busy = req_ready;
    r_wait = 0;
    while (!done && r_wait < 200) begin
      @(negedge clk);
      r_wait++;
    end
    r_done  = done;
    r_fault = fault;
    r_lvl   = fault_level;
    r_meta  = meta_addr;
    r_attr  = {comp_mode, lossy, tile_mode, depth_code, ycr, fmt_code};
    @(negedge clk);
    r_after = done;
    r_reads = rd_cnt - start;
  endtask

  task automatic wr_base(input logic hi, input logic [31:0] d);
    @(negedge clk);
    base_we = 1'b1; base_hi = hi; base_wdata = d;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // tables: top at 0x10_0000, chain A mid 0x20_0000 leaf 0x30_0000,
    // chain B mid 0x40_0000 leaf 0x50_0000; junk in ignored bits
    mem[ea(48'h10_0000, 12'h001)] = 64'hFFFF_0000_0020_7FFF;
    mem[ea(48'h20_0000, 12'h234)] = 64'hABCD_0000_0030_1FFF;
    mem[ea(48'h30_0000, 8'h56)]   = mk_leaf(48'h0000_1234_5600, AT_A);
    mem[ea(48'h30_0000, 8'hA0)]   = mk_leaf(48'hFFFF_FFFF_FF00, AT_B);
    mem[ea(48'h10_0000, 12'hFFF)] = 64'h0000_0000_0040_0001;
    mem[ea(48'h40_0000, 12'h000)] = 64'h0000_0000_0050_0001;
    mem[ea(48'h50_0000, 8'h00)]   = mk_leaf(48'h0000_0000_0100, AT_C);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(req_ready == 1'b1,     "R1 req_ready", req_ready, 1);
    check(done == 1'b0,          "R1 done", done, 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    check(seq_err == 1'b0,       "R1 seq_err", seq_err, 0);

    // R8 zero base: immediate fault, level 3, no reads
    do_lookup(VECS[0].va);
    check(r_done && r_wait == 0, "R8 done latency", r_wait, 0);
    check(r_fault == 1'b1,       "R8 fault", r_fault, 1);
    check(r_lvl == 2'd3,         "R8 fault_level", r_lvl, 3);
    check(r_reads == 0,          "R8 reads", r_reads, 0);

    // R2 upper word only: base = 0x1_0000_0000, top entry absent
    wr_base(1'b1, 32'h0000_0001);
    do_lookup(VECS[0].va);
    check(last_addr == 48'h1_0000_0008, "R2 upper word address", last_addr, 48'h1_0000_0008);
    check(r_fault && r_lvl == 2'd2,     "R2 fault at top", r_lvl, 2);
    check(r_reads == 1,                 "R2 reads", r_reads, 1);

    // R2 low bits [2:0] of base ignored
    wr_base(1'b1, 32'h0);
    wr_base(1'b0, 32'h0010_0005);

    for (int i = 0; i < 6; i++) begin
      do_lookup(VECS[i].va);
      check(r_done == 1'b1,        "R9 done seen", r_done, 1);
      check(r_busy == 1'b0,        "R9 req_ready low while walking", r_busy, 0);
      check(r_after == 1'b0,       "R9 done single cycle", r_after, 0);
      check(r_fault == VECS[i].flt, "R7 fault flag", r_fault, VECS[i].flt);
      if (VECS[i].flt) begin
        check(r_lvl == VECS[i].lvl,  "R7 fault_level", r_lvl, VECS[i].lvl);
        check(r_reads == int'(VECS[i].reads), "R7 reads stop at fault", r_reads, VECS[i].reads);
        check(r_meta == 48'd0 && r_attr == 15'd0, "R7 cleared result", {r_meta, r_attr}, 0);
      end else begin
        check(r_meta == VECS[i].meta, "R3/R4/R5 meta_addr", r_meta, VECS[i].meta);
        check(r_attr == VECS[i].attr, "R6 attributes", r_attr, VECS[i].attr);
        check(r_reads == 3,           "R3 three reads", r_reads, 3);
      end
    end

    // R10 stalled memory request port
    stall_on = 1'b1;
    do_lookup(VECS[0].va);
    check(!r_fault && r_meta == VECS[0].meta, "R10 stalled walk meta", r_meta, VECS[0].meta);
    stall_on = 1'b0;

    // R11 stray response while idle
    @(negedge clk);
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    check(seq_err == 1'b1, "R11 seq_err raised", seq_err, 1);
    @(negedge clk);
    check(seq_err == 1'b0, "R11 seq_err one cycle", seq_err, 0);
    do_lookup(VECS[1].va);
    check(!r_fault && r_meta == VECS[1].meta, "R11 stray ignored", r_meta, VECS[1].meta);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule